// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block sits between a parallel command source and a three-wire serial EEPROM. A command arrives as a one-cycle request that carries an operation, a word address, write data and a word count for reads. The controller raises the device select and clocks out a start bit, a two-bit opcode and the address, followed by the data word for writes. For reads it assembles the returned words and delivers each one with a valid strobe. After a write or erase it lowers the select, waits out a minimum deselect time and raises the select again. It then watches the device's output until the device reports ready, or until a timeout expires.

The serial clock is derived from the system clock by a divider parameter, so the device's maximum serial rate can be met at any system frequency. Word width (8 or 16) and address width match the organisation of the attached part. Only one command runs at a time. The controller also tracks whether programming has been enabled, and it refuses write or erase commands that the device would ignore.

Top module: `eep_host`

## Requirements
- R1: After reset, select, serial clock and serial data out are low, busy, done and read-valid are low, and programming is disabled.
- R2: Operation codes on the request port are read=0, write=1, erase=2, enable=3 and disable=4. Each serial frame starts with a 1 bit. The 2-bit opcode follows: read 10, write 01, erase 11, and 00 for both enable and disable. The address comes next, MSB first. In the address field, enable sends 11 in its top two bits and disable sends 00, with the remaining bits 0. A write then sends its data word MSB first. Serial data out never changes on a cycle where the serial clock rises.
- R3: Each serial clock level lasts exactly CLK_DIV system cycles while a frame runs, and the serial clock is low whenever select is low.
- R4: For a read, the bit on the device output at the end of the last address bit is a dummy and is discarded. The following bits form words, MSB first, each delivered with a one-cycle read-valid pulse. With a count of N the controller collects N consecutive words under one select assertion, with no dummy between words. A count of 0 reads one word.
- R5: A write or erase issued while programming is disabled finishes with done and error set, and no frame is sent. A completed enable frame turns programming on; a completed disable frame turns it off.
- R6: Whenever select falls, it stays low for at least CS_GAP system cycles before it rises again.
- R7: After a write or erase frame and the deselect gap, select is raised again with the clock idle. The command finishes without error once the device output reads 1, which happens only after the device has left its busy state.
- R8: If the device output has not read 1 within POLL_LIMIT cycles of polling, the command finishes with error set, well before a long device busy time ends.
- R9: Busy is high from the cycle after a request is accepted up to and including the single-cycle done pulse. Requests that arrive while busy is high are ignored.
- R10: Operation codes 5 to 7 finish with done and error set, and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command request, accepted when not busy |
| req_op_i | input | 3 | Operation code |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | WORD_W | Data for write |
| req_count_i | input | CNT_W | Words to read, 0 means one |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion status, valid with done_o |
| rd_valid_o | output | 1 | Read word strobe |
| rd_data_o | output | WORD_W | Read word |
| mem_cs_o | output | 1 | Device select |
| mem_sclk_o | output | 1 | Serial clock |
| mem_mosi_o | output | 1 | Serial data to device |
| mem_miso_i | input | 1 | Serial data and ready/busy from device |

## Verification
The assertions check the timing rules on every cycle: the held level of the serial clock, the clock staying idle while deselected, serial data staying still where the clock rises, the minimum deselect gap, and the busy and done handshake. Only the bench scenarios can show that the frame contents are right, that read words come back in order across a burst that wraps the address space, that the dummy bit is dropped, and that refused and timed-out commands report errors. For this the bench uses a behavioural device model and a shadow copy of the memory.

// File: rtl/eep_host_pkg.sv
package eep_host_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WEN   = 3'd3,
    OP_WDIS  = 3'd4
  } eep_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_RX,
    ST_GAP,
    ST_POLL,
    ST_DONE
  } eep_st_e;

  function automatic logic [1:0] op_code(input logic [2:0] op);
    case (op)
      OP_READ:  op_code = 2'b10;
      OP_WRITE: op_code = 2'b01;
      OP_ERASE: op_code = 2'b11;
      default:  op_code = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/eep_sclk_gen.sv
module eep_sclk_gen #(
  parameter int unsigned HALF = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = wrap && !sclk_q;
  assign fall_o = wrap && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/eep_rx_word.sv
module eep_rx_word #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-2:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;
  logic [W-1:0]  data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (shift_i) begin
        sh_q <= {sh_q[W-3:0], bit_i};
        if (cnt_q == CW'(W - 1)) begin
          cnt_q   <= '0;
          valid_q <= 1'b1;
          data_q  <= {sh_q, bit_i};
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

endmodule

// File: rtl/eep_dcnt.sv
module eep_dcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/eep_host.sv
module eep_host
  import eep_host_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned CLK_DIV    = 25,
  parameter int unsigned CS_GAP     = 25,
  parameter int unsigned POLL_LIMIT = 600000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [CNT_W-1:0]  req_count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              mem_cs_o,
  output logic              mem_sclk_o,
  output logic              mem_mosi_o,
  input  logic              mem_miso_i
);
  localparam int unsigned FRAME_W = 3 + ADDR_W + WORD_W;
  localparam int unsigned CMD_W   = 3 + ADDR_W;
  localparam int unsigned BIT_W   = $clog2(FRAME_W + 1);
  localparam int unsigned RX_MAX  = WORD_W * ((1 << CNT_W) - 1);
  localparam int unsigned RX_W    = $clog2(RX_MAX + 1);
  localparam int unsigned TMR_MAX = (POLL_LIMIT > CS_GAP) ? POLL_LIMIT : CS_GAP;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  eep_st_e              st_q;
  logic [2:0]           op_q;
  logic [FRAME_W-1:0]   tx_q;
  logic [BIT_W-1:0]     bits_q;
  logic [RX_W-1:0]      rx_left_q;
  logic                 prog_q, wen_q, err_q, cs_q;

  logic                 sclk_en, rise, fall;
  logic                 tmr_load, tmr_zero;
  logic [TMR_W-1:0]     tmr_val;

  logic [FRAME_W-1:0]   frame_d;
  logic [BIT_W-1:0]     len_d;
  logic [RX_W-1:0]      nwords_d, rx_left_d;
  logic                 op_ok, op_prog;
  logic                 tx_end, rx_end, poll_exit, to_gap, to_poll;

  // request decode
  assign op_ok   = (req_op_i <= OP_WDIS);
  assign op_prog = (req_op_i == OP_WRITE) || (req_op_i == OP_ERASE);

  always_comb begin
    frame_d = '0;
    frame_d[FRAME_W-1] = 1'b1;
    frame_d[FRAME_W-2 -: 2] = op_code(req_op_i);
    case (req_op_i)
      OP_WEN:  frame_d[FRAME_W-4 -: ADDR_W] = {2'b11, {(ADDR_W-2){1'b0}}};
      OP_WDIS: frame_d[FRAME_W-4 -: ADDR_W] = '0;
      default: frame_d[FRAME_W-4 -: ADDR_W] = req_addr_i;
    endcase
    if (req_op_i == OP_WRITE) frame_d[WORD_W-1:0] = req_wdata_i;
    len_d = (req_op_i == OP_WRITE) ? BIT_W'(FRAME_W) : BIT_W'(CMD_W);
  end

  assign nwords_d  = (req_count_i == '0) ? RX_W'(1) : RX_W'(req_count_i);
  assign rx_left_d = nwords_d * RX_W'(WORD_W);

  // phase transitions
  assign tx_end    = (st_q == ST_TX) && fall && (bits_q == BIT_W'(1));
  assign rx_end    = (st_q == ST_RX) && fall && (rx_left_q == RX_W'(1));
  assign poll_exit = (st_q == ST_POLL) && (mem_miso_i || tmr_zero);
  assign to_gap    = (tx_end && (op_q != OP_READ)) || rx_end || poll_exit;
  assign to_poll   = (st_q == ST_GAP) && tmr_zero && prog_q;
  assign tmr_load  = to_gap || to_poll;
  assign tmr_val   = to_poll ? TMR_W'(POLL_LIMIT - 1) : TMR_W'(CS_GAP - 1);
  assign sclk_en   = (st_q == ST_TX) || (st_q == ST_RX);

  eep_sclk_gen #(.HALF(CLK_DIV)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sclk_en),
    .sclk_o (mem_sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  eep_dcnt #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  eep_rx_word #(.W(WORD_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   ((st_q == ST_IDLE) && req_valid_i),
    .shift_i ((st_q == ST_RX) && fall),
    .bit_i   (mem_miso_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= '0;
      tx_q      <= '0;
      bits_q    <= '0;
      rx_left_q <= '0;
      prog_q    <= 1'b0;
      wen_q     <= 1'b0;
      err_q     <= 1'b0;
      cs_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          op_q  <= req_op_i;
          err_q <= 1'b0;
          if (!op_ok || (op_prog && !wen_q)) begin
            err_q <= 1'b1;
            st_q  <= ST_DONE;
          end else begin
            tx_q      <= frame_d;
            bits_q    <= len_d;
            rx_left_q <= rx_left_d;
            prog_q    <= op_prog;
            cs_q      <= 1'b1;
            st_q      <= ST_TX;
          end
        end
        ST_TX: if (fall) begin
          if (bits_q == BIT_W'(1)) begin
            // the device output now holds the read dummy; it is not sampled
            if (op_q == OP_WEN)  wen_q <= 1'b1;
            if (op_q == OP_WDIS) wen_q <= 1'b0;
            if (op_q == OP_READ) begin
              st_q <= ST_RX;
            end else begin
              cs_q <= 1'b0;
              st_q <= ST_GAP;
            end
          end else begin
            tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
            bits_q <= bits_q - BIT_W'(1);
          end
        end
        ST_RX: if (fall) begin
          rx_left_q <= rx_left_q - RX_W'(1);
          if (rx_left_q == RX_W'(1)) begin
            cs_q   <= 1'b0;
            prog_q <= 1'b0;
            st_q   <= ST_GAP;
          end
        end
        ST_GAP: if (tmr_zero) begin
          if (prog_q) begin
            cs_q <= 1'b1;
            st_q <= ST_POLL;
          end else begin
            st_q <= ST_DONE;
          end
        end
        ST_POLL: if (mem_miso_i || tmr_zero) begin
          if (!mem_miso_i) err_q <= 1'b1;
          cs_q   <= 1'b0;
          prog_q <= 1'b0;
          st_q   <= ST_GAP;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign err_o      = done_o && err_q;
  assign mem_cs_o   = cs_q;
  assign mem_mosi_o = (st_q == ST_TX) && tx_q[FRAME_W-1];

  logic unused_rise;
  assign unused_rise = rise;

endmodule

// File: rtl/eep_host_chk.sv
module eep_host_chk #(
  parameter int unsigned CLK_DIV = 25,
  parameter int unsigned CS_GAP  = 25
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic done_i,
  input logic rd_valid_i,
  input logic cs_i,
  input logic sclk_i,
  input logic mosi_i
);
  localparam int unsigned LO_W = $clog2(CS_GAP + 1);
  localparam int unsigned HP_W = $clog2(CLK_DIV + 1);

  logic [LO_W-1:0] lo_q;
  logic [HP_W-1:0] hp_q;
  logic            sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= LO_W'(CS_GAP);
      hp_q   <= HP_W'(CLK_DIV);
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      if (cs_i)                    lo_q <= '0;
      else if (lo_q < LO_W'(CS_GAP)) lo_q <= lo_q + LO_W'(1);
      if (sclk_i != sclk_d)          hp_q <= HP_W'(1);
      else if (hp_q < HP_W'(CLK_DIV)) hp_q <= hp_q + HP_W'(1);
    end
  end

  AST_SCLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i != sclk_d) |-> (hp_q >= HP_W'(CLK_DIV))); // R3
  AST_SCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !sclk_i); // R3
  AST_MOSI_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_i) |-> $stable(mosi_i)); // R2
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_i) |-> (lo_q >= LO_W'(CS_GAP))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R9
  AST_IDLE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !cs_i); // R9
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(done_i)); // R9
  AST_RDV_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |-> busy_i); // R4

endmodule

bind eep_host eep_host_chk #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .rd_valid_i (rd_valid_o),
  .cs_i       (mem_cs_o),
  .sclk_i     (mem_sclk_o),
  .mosi_i     (mem_mosi_o)
);

// File: tb/eep_host_test.sv
module eep_host_test;
  localparam int AW  = 8;
  localparam int WW  = 16;
  localparam int CW  = 4;
  localparam int DIV = 2;
  localparam int GAP = 3;
  localparam int LIM = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [WW-1:0] req_wdata = '0;
  logic [CW-1:0] req_count = '0;
  logic busy_o, done_o, err_o, rd_valid_o, cs, sk, mosi;
  logic [WW-1:0] rd_data_o;
  logic miso;

  always #2 clk = ~clk;

  eep_host #(.ADDR_W(AW), .WORD_W(WW), .CNT_W(CW), .CLK_DIV(DIV),
             .CS_GAP(GAP), .POLL_LIMIT(LIM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_count_i(req_count),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .mem_cs_o(cs), .mem_sclk_o(sk), .mem_mosi_o(mosi),
    .mem_miso_i(miso));

  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [WW-1:0] init_val(input int i);
    return WW'(i * 16'h0101) ^ 16'h5A3C;
  endfunction

  // behavioural device model
  logic [WW-1:0] mem [0:255];
  logic [WW-1:0] shadow [0:255];
  logic [2+AW+WW-1:0] m_shift;
  logic [AW-1:0] m_oaddr, m_paddr, last_addr;
  logic [WW-1:0] m_word, m_pdata;
  logic [1:0] m_op, last_op;
  logic m_started, m_out, m_wen, m_dout, sk_p, cs_p;
  int m_cnt, m_obit, m_pend, m_busy, busy_len;

  assign miso = m_dout;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(i);
      shadow[i] = init_val(i);
    end
    m_shift = '0; m_oaddr = '0; m_paddr = '0; last_addr = '0; m_word = '0;
    m_pdata = '0; m_op = '0; last_op = 2'b11; m_started = 0; m_out = 0;
    m_wen = 0; m_dout = 0; sk_p = 0; cs_p = 0; m_cnt = 0; m_obit = 0;
    m_pend = 0; m_busy = 0; busy_len = 40;
  end

  always @(posedge clk) begin
    if (m_busy > 0) m_busy = m_busy - 1;
    if (!cs) begin
      if (cs_p) begin
        if (m_pend != 0 && m_wen) begin
          mem[m_paddr] = (m_pend == 1) ? m_pdata : '1;
          m_busy = busy_len;
        end
        m_pend = 0;
      end
      m_cnt = 0; m_started = 0; m_out = 0;
      m_dout <= 1'b0;
    end else begin
      if (sk && !sk_p) begin
        if (m_out) begin
          if (m_obit == 0) begin
            m_oaddr = m_oaddr + 1'b1;
            m_word = mem[m_oaddr];
            m_obit = WW;
          end
          m_obit = m_obit - 1;
          m_dout <= m_word[m_obit];
        end else if (!m_started) begin
          if (mosi) m_started = 1;
          m_cnt = 0;
        end else begin
          m_shift = {m_shift[2+AW+WW-2:0], mosi};
          m_cnt = m_cnt + 1;
          if (m_cnt == 2 + AW) begin
            m_op = m_shift[AW+1:AW];
            last_op = m_op;
            last_addr = m_shift[AW-1:0];
            case (m_op)
              2'b10: begin
                m_out = 1; m_oaddr = last_addr; m_word = mem[last_addr];
                m_obit = WW; m_dout <= 1'b0;
              end
              2'b11: begin m_pend = 2; m_paddr = last_addr; end
              2'b01: m_paddr = last_addr;
              default: begin
                if (last_addr[AW-1:AW-2] == 2'b11) m_wen = 1;
                else if (last_addr[AW-1:AW-2] == 2'b00) m_wen = 0;
              end
            endcase
          end
          if (m_cnt == 2 + AW + WW && m_op == 2'b01) begin
            m_pend = 1; m_pdata = m_shift[WW-1:0];
          end
        end
      end
      if (!m_out) m_dout <= (m_busy == 0);
    end
    sk_p = sk;
    cs_p = cs;
  end

  // pin monitors
  int hi_run = 0, hi_min = 1000, hi_max = 0, lo_run = 1000, lo_min = 1000;
  int sk_bad = 0, cs_rises = 0;
  logic cs_m = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (sk) hi_run++;
      else if (hi_run > 0) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
      if (sk && !cs) sk_bad++;
      if (cs && !cs_m) begin
        cs_rises++;
        if (lo_run < lo_min) lo_min = lo_run;
      end
      lo_run = cs ? 0 : lo_run + 1;
      cs_m = cs;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  logic [WW-1:0] rwords [16];
  bit r_err;
  int r_nw, r_cyc;
  bit r_busy_gap;

  task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [WW-1:0] d, input logic [CW-1:0] n,
                         input bit inject);
    bit fin;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d; req_count = n;
    @(negedge clk);
    req_valid = 0;
    r_nw = 0; r_cyc = 0; fin = 0; r_busy_gap = 0; r_err = 0;
    while (!fin) begin
      if (!busy_o) r_busy_gap = 1;
      if (rd_valid_o) begin
        if (r_nw < 16) rwords[r_nw] = rd_data_o;
        r_nw++;
      end
      if (done_o) begin
        fin = 1; r_err = err_o;
      end else begin
        if (inject && r_cyc == 8) begin
          req_valid = 1; req_op = 3'd1; req_addr = 8'h40; req_wdata = 16'h0000;
        end
        if (inject && r_cyc == 9) req_valid = 0;
        @(negedge clk);
        r_cyc++;
      end
    end
    req_valid = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int n, input string rq);
    int exp_n;
    exp_n = (n == 0) ? 1 : n;
    run_cmd(3'd0, a, '0, CW'(n), 0);
    check(!r_err && r_nw == exp_n, rq, r_nw, exp_n);
    check(last_op == 2'b10 && last_addr == a, "R2 read frame", {last_op, last_addr}, {2'b10, a});
    for (int i = 0; i < exp_n && i < 16; i++)
      check(rwords[i] == shadow[AW'(a + i)], rq, rwords[i], shadow[AW'(a + i)]);
  endtask

  task automatic do_prog(input bit is_write, input logic [AW-1:0] a,
                         input logic [WW-1:0] d);
    run_cmd(is_write ? 3'd1 : 3'd2, a, d, '0, 0);
    check(!r_err, "R7 program ok", r_err, 0);
    check(m_busy == 0, "R7 ready seen", m_busy, 0);
    check(last_op == (is_write ? 2'b01 : 2'b11) && last_addr == a, "R2 program frame",
          {last_op, last_addr}, {(is_write ? 2'b01 : 2'b11), a});
    shadow[a] = is_write ? d : '1;
  endtask

  int rises0;
  bit all_done = 0;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!cs && !sk && !mosi, "R1 pins", {cs, sk, mosi}, 0);
    check(!busy_o && !done_o && !rd_valid_o, "R1 status", {busy_o, done_o, rd_valid_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R5 programming disabled after reset
    rises0 = cs_rises;
    run_cmd(3'd1, 8'h20, 16'h1234, '0, 0);
    check(r_err == 1, "R5 refused write err", r_err, 1);
    check(cs_rises == rises0, "R5 no frame", cs_rises, rises0);
    do_read(8'h20, 1, "R5 memory untouched");

    // R10 invalid codes
    for (int c = 5; c < 8; c++) begin
      rises0 = cs_rises;
      run_cmd(3'(c), 8'h00, '0, '0, 0);
      check(r_err == 1, "R10 invalid err", r_err, 1);
      check(cs_rises == rises0, "R10 no frame", cs_rises, rises0);
    end

    // R5 enable
    run_cmd(3'd3, 8'h00, '0, '0, 0);
    check(!r_err, "R5 enable ok", r_err, 0);
    check(last_op == 2'b00 && last_addr[AW-1:AW-2] == 2'b11, "R2 enable frame",
          {last_op, last_addr}, {2'b00, 8'hC0});

    // R7 write then erase
    do_prog(1, 8'h10, 16'hBEEF);
    do_read(8'h10, 1, "R4 readback write");
    do_prog(0, 8'h11, '0);
    do_read(8'h11, 1, "R4 readback erase");

    // R4 bursts, wrap, count zero
    do_read(8'hFE, 4, "R4 burst wrap");
    do_read(8'h05, 0, "R4 count zero");
    do_read(8'h10, 15, "R4 long burst");

    // R9 request while busy ignored
    run_cmd(3'd0, 8'h30, '0, 4'd3, 1);
    check(r_nw == 3 && !r_err, "R9 burst unaffected", r_nw, 3);
    check(!r_busy_gap, "R9 busy held", r_busy_gap, 0);
    do_read(8'h40, 1, "R9 injected write ignored");

    // R8 timeout
    busy_len = 1000;
    run_cmd(3'd1, 8'h50, 16'hA5A5, '0, 0);
    shadow[8'h50] = 16'hA5A5;
    check(r_err == 1, "R8 timeout err", r_err, 1);
    check(r_cyc < 700, "R8 early abort", r_cyc, 700);
    repeat (1100) @(negedge clk);
    busy_len = 40;
    do_read(8'h50, 1, "R8 data after busy");

    // R5 disable then refused
    run_cmd(3'd4, 8'h00, '0, '0, 0);
    check(!r_err && last_op == 2'b00 && last_addr[AW-1:AW-2] == 2'b00, "R2 disable frame",
          {last_op, last_addr}, 0);
    rises0 = cs_rises;
    run_cmd(3'd2, 8'h10, '0, '0, 0);
    check(r_err == 1 && cs_rises == rises0, "R5 refused after disable", r_err, 1);
    do_read(8'h10, 1, "R5 erase blocked");
    run_cmd(3'd3, 8'h00, '0, '0, 0);

    // random traffic
    for (int k = 0; k < 60; k++) begin
      int sel;
      logic [AW-1:0] a;
      sel = $urandom % 3;
      a = AW'($urandom);
      if (sel == 0) do_prog(1, a, WW'($urandom));
      else if (sel == 1) do_prog(0, a, '0);
      else do_read(a, 1 + ($urandom % 3), "R4 random read");
    end

    // pin timing
    check(hi_min == DIV && hi_max == DIV, "R3 sclk high phase", hi_max, DIV);
    check(sk_bad == 0, "R3 sclk idle when deselected", sk_bad, 0);
    check(lo_min >= GAP, "R6 deselect gap", lo_min, GAP);
    all_done = 1;
  end

  initial begin
    fork
      begin
        wait (all_done);
      end
      begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule